// File: doc/BRIEF.md
# Twin-Predicated Element Mover

This block sequences element moves from a source vector region into a destination vector region. Each side has its own predicate mask and its own step counter. The source step skips disabled source elements, and the destination step skips disabled destination slots. The k-th enabled source element is paired with the k-th enabled destination slot. The block does not hold the register file, and it does not perform any element operation. For each move it puts out a read index with a strobe and a write index with a strobe, in the same cycle. The register array around it performs the copy.

Each side can be flagged as scalar or vector, so one sequencer covers the usual cases without dedicated opcodes:

- a vector source into a vector destination gives compress, expand, or compress followed by expand;
- a scalar source into a vector destination gives a splat;
- a vector source into a scalar destination gives an extract;
- a one-hot mask gives an insert.

A single-predicate mode locks both steps to one mask.

A start pulse captures the vector length, the masks and the flags. Moves are issued at most one per cycle while `ready` is high. When no further pair exists, `done` rises and stays high until the next start.

Top module: `twin_pred_mover`

## Requirements
- R1: After reset `busy`, `done`, `rd_en` and `wr_en` are all 0.
- R2: When both sides are vector and predicated, the k-th set bit of the source mask (from bit 0 upward) is read as `rd_idx`, in the same cycle as the k-th set bit of the destination mask is written as `wr_idx`. The result equals a compress of the source followed by an expand into the destination.
- R3: When a side's predicate-enable input is 0, that side's mask is taken as all ones below `vl`. With only the destination unpredicated the move is a compress; with only the source unpredicated it is an expand.
- R4: When the source is scalar (`src_vec`=0) and the destination is vector, `rd_idx` is 0 for every move, the source mask is ignored, and every enabled destination slot below `vl` is written once.
- R5: When the source is vector and the destination is scalar (`dst_vec`=0), exactly one move happens, from the first enabled source element to `wr_idx`=0, and `done` rises in the next cycle.
- R6: When `single_pred` is 1, both sides are treated as vector, the source mask (or all ones, when the source is unpredicated) is used for both sides, and every move has `rd_idx` equal to `wr_idx`.
- R7: The transfer ends as soon as either side has no enabled element left below `vl`. Enabled slots left over on the other side are not written.
- R8: An all-zero mask on a vector side produces no strobes, and `done` rises after one busy cycle.
- R9: At most one move is issued per cycle, and no strobe is issued while `ready` is 0. With `ready` held at 1, a vector-destination run of N moves is busy for N+1 cycles.
- R10: Mask bits at or above `vl` are ignored.
- R11: A one-hot mask (1 shifted left by n) selects exactly one element, so a scalar source into a one-hot destination mask is a single insert at slot n.
- R12: `done` stays 1 until the next `start`. A new `start` in the done state clears `done` and sets `busy` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer; accepted when not busy |
| ready | input | 1 | Allows a move in this cycle |
| vl | input | LENW | Vector length, 0..MAXVL |
| src_mask | input | MAXVL | Source predicate |
| dst_mask | input | MAXVL | Destination predicate |
| src_pred_en | input | 1 | 0: the source mask is treated as all ones |
| dst_pred_en | input | 1 | 0: the destination mask is treated as all ones |
| src_vec | input | 1 | 1: the source is a vector, 0: the source is scalar |
| dst_vec | input | 1 | 1: the destination is a vector, 0: the destination is scalar |
| single_pred | input | 1 | Both steps use the source mask and move together |
| rd_idx | output | IDXW | Source element index |
| rd_en | output | 1 | Read strobe |
| wr_idx | output | IDXW | Destination element index |
| wr_en | output | 1 | Write strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished |

## Verification
Twin masks with different bit counts on each side show whether the two steps truly run independently and whether the run stops at the shorter side. Unpredicated-source and unpredicated-destination runs separate expand from compress. Splat, extract and one-hot insert separate the effect of the scalar flags from the effect of the masks. An all-zero mask, set mask bits above `vl`, a broken `ready` pattern and single-predicate mode each tell apart a correct end condition, length clamp, stall behaviour and step lock from a design that only gets the common case right.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} tpm_state_e;
endpackage

// File: rtl/tpm_scan.sv
module tpm_scan #(
  parameter int MAXVL = 16,
  parameter int IDXW  = $clog2(MAXVL),
  parameter int LENW  = $clog2(MAXVL + 1)
) (
  input  logic [MAXVL-1:0] mask,
  input  logic [LENW-1:0]  from,
  input  logic             is_vec,
  output logic             hit,
  output logic [IDXW-1:0]  idx
);
  // lowest enabled element at or above the step; a scalar side is always element 0
  always_comb begin
    hit = 1'b0;
    idx = '0;
    if (!is_vec) begin
      hit = 1'b1;
    end else begin
      for (int i = MAXVL - 1; i >= 0; i--) begin
        if (mask[i] && (i >= int'(from))) begin
          hit = 1'b1;
          idx = IDXW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/tpm_step.sv
module tpm_step #(
  parameter int IDXW = 4,
  parameter int LENW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  input  logic [IDXW-1:0] idx,
  output logic [LENW-1:0] step
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   step <= '0;
    else if (clr) step <= '0;
    else if (adv) step <= LENW'(idx) + LENW'(1);
  end

  // R2
  step_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (LENW'(idx) >= step));
endmodule

// File: rtl/twin_pred_mover.sv
module twin_pred_mover
  import tpm_pkg::*;
#(
  parameter int MAXVL = 16,
  parameter int IDXW  = $clog2(MAXVL),
  parameter int LENW  = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ready,
  input  logic [LENW-1:0]  vl,
  input  logic [MAXVL-1:0] src_mask,
  input  logic [MAXVL-1:0] dst_mask,
  input  logic             src_pred_en,
  input  logic             dst_pred_en,
  input  logic             src_vec,
  input  logic             dst_vec,
  input  logic             single_pred,
  output logic [IDXW-1:0]  rd_idx,
  output logic             rd_en,
  output logic [IDXW-1:0]  wr_idx,
  output logic             wr_en,
  output logic             busy,
  output logic             done
);
  function automatic logic [MAXVL-1:0] len_mask(input logic [LENW-1:0] n);
    logic [MAXVL-1:0] m;
    for (int i = 0; i < MAXVL; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  function automatic logic [MAXVL-1:0] eff_mask(input logic [MAXVL-1:0] m,
                                                input logic en,
                                                input logic [LENW-1:0] n);
    return (en ? m : {MAXVL{1'b1}}) & len_mask(n);
  endfunction

  tpm_state_e       st;
  logic [LENW-1:0]  vl_q;
  logic [MAXVL-1:0] smask_q, dmask_q;
  logic             sv_q, dv_q, single_q;

  logic             accept, s_hit, d_hit, xfer, exhausted, last_one;
  logic [IDXW-1:0]  s_idx, d_idx;
  logic [LENW-1:0]  s_step, d_step;

  assign accept    = start && (st != ST_RUN);
  assign xfer      = (st == ST_RUN) && s_hit && d_hit && ready;
  assign exhausted = (st == ST_RUN) && !(s_hit && d_hit);
  assign last_one  = xfer && !dv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      vl_q     <= '0;
      smask_q  <= '0;
      dmask_q  <= '0;
      sv_q     <= 1'b0;
      dv_q     <= 1'b0;
      single_q <= 1'b0;
    end else if (accept) begin
      st       <= ST_RUN;
      vl_q     <= vl;
      smask_q  <= eff_mask(src_mask, src_pred_en, vl);
      dmask_q  <= single_pred ? eff_mask(src_mask, src_pred_en, vl)
                              : eff_mask(dst_mask, dst_pred_en, vl);
      sv_q     <= src_vec | single_pred;
      dv_q     <= dst_vec | single_pred;
      single_q <= single_pred;
    end else if (exhausted || last_one) begin
      st <= ST_FIN;
    end
  end

  tpm_scan #(.MAXVL(MAXVL), .IDXW(IDXW), .LENW(LENW)) src_scan_i (
    .mask(smask_q), .from(s_step), .is_vec(sv_q), .hit(s_hit), .idx(s_idx));
  tpm_scan #(.MAXVL(MAXVL), .IDXW(IDXW), .LENW(LENW)) dst_scan_i (
    .mask(dmask_q), .from(d_step), .is_vec(dv_q), .hit(d_hit), .idx(d_idx));

  tpm_step #(.IDXW(IDXW), .LENW(LENW)) src_step_i (
    .clk(clk), .rst_n(rst_n), .clr(accept), .adv(xfer && sv_q),
    .idx(s_idx), .step(s_step));
  tpm_step #(.IDXW(IDXW), .LENW(LENW)) dst_step_i (
    .clk(clk), .rst_n(rst_n), .clr(accept), .adv(xfer && dv_q),
    .idx(d_idx), .step(d_step));

  assign rd_en  = xfer;
  assign wr_en  = xfer;
  assign rd_idx = s_idx;
  assign wr_idx = d_idx;
  assign busy   = (st == ST_RUN);
  assign done   = (st == ST_FIN);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !(wr_en || busy || done));
  // R7
  dst_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (LENW'(wr_idx) < vl_q || !dv_q));
  // R2
  dst_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dv_q) |-> dmask_q[wr_idx]);
  // R2
  src_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sv_q) |-> smask_q[rd_idx]);
  // R4
  splat_src_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !sv_q) |-> (rd_idx == '0));
  // R5
  extract_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !dv_q) |=> (done && !wr_en));
  // R6
  single_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && single_q) |-> (rd_idx == wr_idx));
  // R12
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: tb/twin_pred_mover_tb.sv
module twin_pred_mover_tb_top;
  localparam int MAXVL = 16;
  localparam int IDXW  = 4;
  localparam int LENW  = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, ready = 1;
  logic [LENW-1:0] vl = '0;
  logic [MAXVL-1:0] src_mask = '0, dst_mask = '0;
  logic src_pred_en = 0, dst_pred_en = 0, src_vec = 1, dst_vec = 1, single_pred = 0;
  logic [IDXW-1:0] rd_idx, wr_idx;
  logic rd_en, wr_en, busy, done;

  int errors = 0, checks = 0;
  logic [7:0] src_rf [MAXVL];
  logic [7:0] dst_rf [MAXVL];
  logic [7:0] exp_rf [MAXVL];

  always #4 clk = ~clk;

  twin_pred_mover #(.MAXVL(MAXVL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .vl(vl),
    .src_mask(src_mask), .dst_mask(dst_mask), .src_pred_en(src_pred_en),
    .dst_pred_en(dst_pred_en), .src_vec(src_vec), .dst_vec(dst_vec),
    .single_pred(single_pred), .rd_idx(rd_idx), .rd_en(rd_en),
    .wr_idx(wr_idx), .wr_en(wr_en), .busy(busy), .done(done));

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Runs one transfer and compares against a list-based model of the pairing.
  task automatic run_case(input string req, input int n, input logic [15:0] sm,
                          input logic [15:0] dm, input logic spe, input logic dpe,
                          input logic sv, input logic dv, input logic sgl,
                          input logic [15:0] rdy_pat);
    int sl[$]; int dl[$];
    int npairs, got, cyc, busy_cyc;
    logic [15:0] se, de;
    logic svx, dvx;
    for (int i = 0; i < MAXVL; i++) begin
      dst_rf[i] = 8'hE0 + 8'(i);
      exp_rf[i] = dst_rf[i];
    end
    // model: list enabled indices of each side, then pair them in order
    svx = sv | sgl; dvx = dv | sgl;
    se = spe ? sm : 16'hFFFF;
    de = sgl ? se : (dpe ? dm : 16'hFFFF);
    for (int i = 0; i < n; i++) begin
      if (se[i]) sl.push_back(i);
      if (de[i]) dl.push_back(i);
    end
    if (!svx) begin sl.delete(); for (int i = 0; i < MAXVL; i++) sl.push_back(0); end
    if (!dvx) begin dl.delete(); dl.push_back(0); end
    npairs = (sl.size() < dl.size()) ? sl.size() : dl.size();
    for (int k = 0; k < npairs; k++) exp_rf[dl[k]] = src_rf[sl[k]];

    @(negedge clk);
    vl = LENW'(n); src_mask = sm; dst_mask = dm; src_pred_en = spe; dst_pred_en = dpe;
    src_vec = sv; dst_vec = dv; single_pred = sgl; start = 1;
    @(negedge clk);
    start = 0;
    check({req, " R12 busy after start"}, int'(busy && !done), 1);
    got = 0; cyc = 0; busy_cyc = 0;
    while (!done && cyc < 200) begin
      ready = rdy_pat[cyc % 16];
      #1;
      if (busy) busy_cyc++;
      if (wr_en) begin
        if (!ready) check({req, " R9 strobe while not ready"}, 1, 0);
        check({req, " R2 rd_en with wr_en"}, int'(rd_en), 1);
        if (got < npairs) begin
          check({req, " R2 rd_idx"}, int'(rd_idx), sl[got]);
          check({req, " R2 wr_idx"}, int'(wr_idx), dl[got]);
          if (sgl) check({req, " R6 lockstep"}, int'(rd_idx), int'(wr_idx));
        end
        dst_rf[wr_idx] = src_rf[rd_idx];
        got++;
      end
      @(negedge clk);
      cyc++;
    end
    ready = 1;
    check({req, " R7 done reached"}, int'(done), 1);
    check({req, " R7 move count"}, got, npairs);
    if (rdy_pat == 16'hFFFF)
      check({req, " R9 busy cycles"}, busy_cyc, dvx ? npairs + 1 : 1);
    for (int i = 0; i < MAXVL; i++)
      if (dst_rf[i] != exp_rf[i])
        check({req, $sformatf(" R7 dst[%0d]", i)}, int'(dst_rf[i]), int'(exp_rf[i]));
    checks++;
  endtask

  initial begin
    for (int i = 0; i < MAXVL; i++) src_rf[i] = 8'h40 + 8'(3 * i);
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 wr_en", int'(wr_en), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle after release", int'(busy || done || rd_en), 0);

    // R2 twin masks: compress then expand
    run_case("R2 twin", 8, 16'h00B6, 16'h0059, 1, 1, 1, 1, 0, 16'hFFFF);
    // R3 compress (destination unpredicated)
    run_case("R3 compress", 10, 16'h0225, 16'h0000, 1, 0, 1, 1, 0, 16'hFFFF);
    // R3 expand (source unpredicated)
    run_case("R3 expand", 10, 16'h0000, 16'h0292, 0, 1, 1, 1, 0, 16'hFFFF);
    // R4 splat, source mask zero is ignored
    run_case("R4 splat", 6, 16'h0000, 16'h002D, 1, 1, 0, 1, 0, 16'hFFFF);
    // R5 extract first enabled source element
    run_case("R5 extract", 12, 16'h0C30, 16'h0000, 1, 1, 1, 0, 0, 16'hFFFF);
    // R11 insert via one-hot destination mask
    run_case("R11 insert", 16, 16'h0000, 16'h0001 << 9, 0, 1, 0, 1, 0, 16'hFFFF);
    // R11 one-hot source into scalar destination
    run_case("R11 onehot src", 16, 16'h0001 << 13, 16'h0000, 1, 0, 1, 0, 0, 16'hFFFF);
    // R6 single predicate, destination mask input ignored
    run_case("R6 single", 9, 16'h0153, 16'h00FF, 1, 1, 1, 1, 1, 16'hFFFF);
    // R7 source runs out first; leftover destination slots untouched
    run_case("R7 short src", 16, 16'h8100, 16'h7C00, 1, 1, 1, 1, 0, 16'hFFFF);
    // R7 destination runs out first
    run_case("R7 short dst", 16, 16'hFFFF, 16'h0110, 1, 1, 1, 1, 0, 16'hFFFF);
    // R8 all-zero mask on a vector side
    run_case("R8 zero src", 8, 16'h0000, 16'h00FF, 1, 1, 1, 1, 0, 16'hFFFF);
    run_case("R8 zero dst", 8, 16'h00FF, 16'h0000, 1, 1, 1, 1, 0, 16'hFFFF);
    // R9 stalls from ready
    run_case("R9 stall", 12, 16'h0EEF, 16'h0F7B, 1, 1, 1, 1, 0, 16'b1001_0110_0011_0101);
    // R10 mask bits above vl ignored
    run_case("R10 clamp", 5, 16'hFFFF, 16'hFFE3, 1, 1, 1, 1, 0, 16'hFFFF);

    // R12 done holds while idle
    repeat (3) @(negedge clk);
    check("R12 done held", int'(done), 1);
    check("R12 no strobe when done", int'(wr_en), 0);
    run_case("R12 restart", 4, 16'h000F, 16'h000F, 1, 1, 1, 1, 0, 16'hFFFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule